// File: doc/BRIEF.md
# Transmit Descriptor Timestamp Close Engine

This block is the part of a transmit DMA engine that fetches, hands off and closes four-word transmit descriptors kept in a word-addressed memory. It reads a descriptor and checks the ownership flag. It then presents both buffer pointers and byte counts to a data mover through a request/done handshake. When the mover reports the frame as sent, the block closes the descriptor. If that descriptor asked for a timestamp and ends a frame, the block first overwrites the two pointer words with the 64-bit timestamp captured at completion. It then writes the control word back with the ownership flag cleared and a status flag recording whether a timestamp was stored.

After each close the engine moves on to the next descriptor. In chained mode the next address comes from a pointer in word 3, which is latched at fetch time so that the timestamp overwrite cannot destroy it. In ring mode the descriptors sit at a fixed stride, and a wrap flag returns the engine to a programmed base. When the engine meets a descriptor it does not own, it stops and waits for a poll-demand pulse before it fetches the same descriptor again.

Top module: `txd_ts_closer`

## Requirements
- R1: After reset `suspended` is 1, `xfer_req` is 0 and no memory access is made until a `poll_demand` pulse; the first fetch then starts at `ring_base`.
- R2: A fetch issues four reads, at the descriptor address plus 0, 4, 8 and 12 in that order, one per cycle, with `mem_rdata` valid the cycle after each read.
- R3: If bit 31 (ownership) of word 0 is 0, no request is raised, `suspended` goes to 1 and no memory access follows until `poll_demand`, which re-fetches the same address.
- R4: For an owned descriptor `xfer_req` is held until `xfer_done`, with buffer 1 address = word 2, buffer 1 length = word 1 bits [12:0], buffer 2 address = word 3, buffer 2 length = word 1 bits [28:16] (0 when word 1 bit 24 is set) and `xfer_last` = word 0 bit 29.
- R5: When word 0 bit 25 (timestamp request) and bit 29 (last segment) are both 1, word 2 receives `ts_value[31:0]` and word 3 receives `ts_value[63:32]`, with `ts_value` sampled in the cycle `xfer_done` is 1.
- R6: The writes of a close are ordered: word 2 and then word 3 (when a timestamp is stored), and word 0 always last, before the next fetch.
- R7: The closing word 0 equals the fetched word 0 with bit 31 cleared and bit 17 set to 1 exactly when a timestamp was stored (cleared otherwise), all other bits unchanged.
- R8: When either bit 25 or bit 29 of word 0 is 0, only word 0 is written and words 2 and 3 keep their values.
- R9: When word 1 bit 24 (chained) is 1, the next descriptor address is the fetched word 3 with its two low bits cleared, even after word 3 was overwritten.
- R10: When word 1 bit 24 is 0, the next descriptor address is the current address plus 16, or `ring_base` when word 0 bit 21 (end of ring) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_demand | input | 1 | Pulse that restarts fetching while suspended |
| ring_base | input | AW | Byte address of the first descriptor and the ring wrap target |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address of the memory word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| xfer_req | output | 1 | Frame transfer request to the data mover |
| xfer_buf1_addr | output | 32 | Buffer 1 address |
| xfer_buf1_len | output | 13 | Buffer 1 byte count |
| xfer_buf2_addr | output | 32 | Buffer 2 address |
| xfer_buf2_len | output | 13 | Buffer 2 byte count |
| xfer_last | output | 1 | Descriptor ends the frame |
| xfer_done | input | 1 | Data mover finished the frame |
| ts_value | input | TS_W | Timestamp captured for the frame |
| suspended | output | 1 | Engine halted on a descriptor it does not own |

## Verification
The assertions take for granted that `ring_base` and every chained pointer target are word aligned once their low bits are dropped. They also assume that `xfer_done` is raised only while `xfer_req` is high and that the memory returns read data exactly one cycle after each read. The stimulus keeps the base at a fixed aligned slot and draws chained targets from whole descriptor slots, with random low bits that the engine must strip. It gives `xfer_done` as a single-cycle pulse after a random wait inside the request, and models a memory with that fixed read latency.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned LEN_W   = 13;
   localparam int unsigned OWN_B   = 31;
   localparam int unsigned LS_B    = 29;
   localparam int unsigned TSEN_B  = 25;
   localparam int unsigned EOR_B   = 21;
   localparam int unsigned TSST_B  = 17;
   localparam int unsigned CHAIN_B = 24;
   localparam int unsigned LEN2_LO = 16;

   typedef struct packed {
      logic [WORD_W-1:0] hi;
      logic [WORD_W-1:0] lo;
      logic [WORD_W-1:0] cnt;
      logic [WORD_W-1:0] ctl;
   } txd_desc_t;

   typedef enum logic [3:0] {
      ST_SUSP, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_CHK,
      ST_REQ, ST_WLO, ST_WHI, ST_WCTL
   } txd_state_e;
endpackage

// File: rtl/txd_desc_latch.sv
module txd_desc_latch
   import txd_pkg::*;
#(
   parameter int unsigned WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [WORDS-1:0]              cap_en,
   input  logic [WORD_W-1:0]             rdata,
   output logic [WORDS-1:0][WORD_W-1:0]  words
);
   generate
      if (WORDS != 4) begin : g_bad_words
         $error("txd_desc_latch: WORDS must be 4");
      end
      for (genvar g = 0; g < WORDS; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         words[g] <= '0;
            else if (cap_en[g]) words[g] <= rdata;
         end
      end
   endgenerate

   // each returning read word lands in exactly one slot
   assert_cap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cap_en));
endmodule

// File: rtl/txd_next_ptr.sv
module txd_next_ptr #(
   parameter int unsigned AW        = 16,
   parameter int unsigned STRIDE    = 16,
   parameter int unsigned BUS_BYTES = 4
) (
   input  logic [AW-1:0] cur_addr,
   input  logic [AW-1:0] ring_base,
   input  logic          chained,
   input  logic          wrap,
   input  logic [AW-1:0] chain_ptr,
   output logic [AW-1:0] next_addr
);
   localparam logic [AW-1:0] LOW_MASK = AW'(BUS_BYTES - 1);
   localparam logic [AW-1:0] STEP     = AW'(STRIDE);

   generate
      if ((BUS_BYTES & (BUS_BYTES - 1)) != 0 || BUS_BYTES < 4) begin : g_bad_bus
         $error("txd_next_ptr: BUS_BYTES must be a power of two, at least 4");
      end
      if (STRIDE < 16 || (STRIDE & (STRIDE - 1)) != 0) begin : g_bad_stride
         $error("txd_next_ptr: STRIDE must be a power of two, at least 16");
      end
   endgenerate

   logic [AW-1:0] ring_next;

   always_comb begin
      ring_next = wrap ? ring_base : cur_addr + STEP;
      next_addr = chained ? (chain_ptr & ~LOW_MASK) : ring_next;
   end
endmodule

// File: rtl/txd_seq.sv
module txd_seq
   import txd_pkg::*;
#(
   parameter int unsigned AW   = 16,
   parameter int unsigned TS_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_demand,
   input  logic [AW-1:0]     ring_base,
   input  logic [AW-1:0]     next_addr,
   input  logic [WORD_W-1:0] ctl_word,
   input  logic              xfer_done,
   input  logic [TS_W-1:0]   ts_value,
   output logic [3:0]        cap_en,
   output logic [AW-1:0]     cur_addr,
   output logic              mem_en,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              xfer_req,
   output logic              suspended
);
   generate
      if (TS_W != 2 * WORD_W) begin : g_bad_ts
         $error("txd_seq: TS_W must be two words");
      end
   endgenerate

   txd_state_e        state;
   logic              armed;
   logic [TS_W-1:0]   ts_q;
   logic [1:0]        wr_cnt;
   logic [AW-1:0]     offs;
   logic              want_ts;
   logic [WORD_W-1:0] close_word;

   assign want_ts = ctl_word[TSEN_B] & ctl_word[LS_B];

   always_comb begin
      close_word         = ctl_word;
      close_word[OWN_B]  = 1'b0;
      close_word[TSST_B] = want_ts;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SUSP;
         cur_addr <= '0;
         armed    <= 1'b0;
         ts_q     <= '0;
         wr_cnt   <= '0;
      end else begin
         case (state)
            ST_SUSP: if (poll_demand) begin
               state <= ST_RD0;
               armed <= 1'b1;
               if (!armed) cur_addr <= ring_base;
            end
            ST_RD0: begin
               state  <= ST_RD1;
               wr_cnt <= '0;
            end
            ST_RD1: state <= ST_RD2;
            ST_RD2: state <= ST_RD3;
            ST_RD3: state <= ST_CHK;
            ST_CHK: state <= ctl_word[OWN_B] ? ST_REQ : ST_SUSP;
            ST_REQ: if (xfer_done) begin
               ts_q  <= ts_value;
               state <= want_ts ? ST_WLO : ST_WCTL;
            end
            ST_WLO: begin
               wr_cnt <= wr_cnt + 2'd1;
               state  <= ST_WHI;
            end
            ST_WHI: begin
               wr_cnt <= wr_cnt + 2'd1;
               state  <= ST_WCTL;
            end
            ST_WCTL: begin
               cur_addr <= next_addr;
               state    <= ST_RD0;
            end
            default: state <= ST_SUSP;
         endcase
      end
   end

   always_comb begin
      cap_en    = 4'b0000;
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      offs      = '0;
      mem_wdata = '0;
      case (state)
         ST_RD0:  mem_en = 1'b1;
         ST_RD1:  begin mem_en = 1'b1; offs = AW'(4);  cap_en = 4'b0001; end
         ST_RD2:  begin mem_en = 1'b1; offs = AW'(8);  cap_en = 4'b0010; end
         ST_RD3:  begin mem_en = 1'b1; offs = AW'(12); cap_en = 4'b0100; end
         ST_CHK:  cap_en = 4'b1000;
         ST_WLO:  begin
            mem_en = 1'b1; mem_we = 1'b1; offs = AW'(8);
            mem_wdata = ts_q[WORD_W-1:0];
         end
         ST_WHI:  begin
            mem_en = 1'b1; mem_we = 1'b1; offs = AW'(12);
            mem_wdata = ts_q[TS_W-1:WORD_W];
         end
         ST_WCTL: begin
            mem_en = 1'b1; mem_we = 1'b1;
            mem_wdata = close_word;
         end
         default: ;
      endcase
      mem_addr  = cur_addr + offs;
      xfer_req  = (state == ST_REQ);
      suspended = (state == ST_SUSP);
   end

   // suspension is entered only because the fetched control word is not owned
   assert_suspend_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> !ctl_word[OWN_B]);

   // request stays up until the mover answers
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_done |=> xfer_req);

   // a request is only made for an owned descriptor
   assert_req_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> ctl_word[OWN_B]);

   // word 0 write comes after both timestamp writes, or after none
   assert_ctl_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && mem_addr == cur_addr) |->
         (wr_cnt == (want_ts ? 2'd2 : 2'd0)));

   // status flag mirrors whether timestamp words were written; ownership released
   assert_ts_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && mem_addr == cur_addr) |->
         ((mem_wdata[TSST_B] == (wr_cnt == 2'd2)) && !mem_wdata[OWN_B]));

   // every access, chained targets included, is word aligned
   assert_addr_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/txd_ts_closer.sv
module txd_ts_closer
   import txd_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned TS_W      = 64,
   parameter int unsigned STRIDE    = 16,
   parameter int unsigned BUS_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_demand,
   input  logic [AW-1:0]     ring_base,
   output logic              mem_en,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              xfer_req,
   output logic [31:0]       xfer_buf1_addr,
   output logic [12:0]       xfer_buf1_len,
   output logic [31:0]       xfer_buf2_addr,
   output logic [12:0]       xfer_buf2_len,
   output logic              xfer_last,
   input  logic              xfer_done,
   input  logic [TS_W-1:0]   ts_value,
   output logic              suspended
);
   generate
      if (AW < 8 || AW > WORD_W) begin : g_bad_aw
         $error("txd_ts_closer: AW must lie between 8 and 32");
      end
   endgenerate

   logic [3:0]             cap_en;
   logic [3:0][WORD_W-1:0] words;
   txd_desc_t              desc;
   logic [AW-1:0]          cur_addr;
   logic [AW-1:0]          next_addr;
   logic                   unused_cnt_bits;
   logic                   unused_hi_bits;

   assign desc.ctl = words[0];
   assign desc.cnt = words[1];
   assign desc.lo  = words[2];
   assign desc.hi  = words[3];

   txd_desc_latch #(.WORDS(4)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .rdata  (mem_rdata),
      .words  (words)
   );

   txd_next_ptr #(.AW(AW), .STRIDE(STRIDE), .BUS_BYTES(BUS_BYTES)) u_next (
      .cur_addr  (cur_addr),
      .ring_base (ring_base),
      .chained   (desc.cnt[CHAIN_B]),
      .wrap      (desc.ctl[EOR_B]),
      .chain_ptr (desc.hi[AW-1:0]),
      .next_addr (next_addr)
   );

   txd_seq #(.AW(AW), .TS_W(TS_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .poll_demand (poll_demand),
      .ring_base   (ring_base),
      .next_addr   (next_addr),
      .ctl_word    (desc.ctl),
      .xfer_done   (xfer_done),
      .ts_value    (ts_value),
      .cap_en      (cap_en),
      .cur_addr    (cur_addr),
      .mem_en      (mem_en),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .xfer_req    (xfer_req),
      .suspended   (suspended)
   );

   assign xfer_buf1_addr  = desc.lo;
   assign xfer_buf1_len   = desc.cnt[LEN_W-1:0];
   assign xfer_buf2_addr  = desc.hi;
   assign xfer_buf2_len   = desc.cnt[CHAIN_B] ? '0 : desc.cnt[LEN2_LO +: LEN_W];
   assign xfer_last       = desc.ctl[LS_B];
   assign unused_cnt_bits = ^{desc.cnt[31:29], desc.cnt[15:13]};
   assign unused_hi_bits  = ^desc.hi;
endmodule

// File: tb/txd_ts_closer_test.sv
`timescale 1ns/1ps
module txd_ts_closer_test;
   localparam logic [15:0] BASE = 16'h0030;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        poll_demand = 1'b0;
   logic        mem_en, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        xfer_req, xfer_last, suspended;
   logic [31:0] xfer_buf1_addr, xfer_buf2_addr;
   logic [12:0] xfer_buf1_len, xfer_buf2_len;
   logic        xfer_done = 1'b0;
   logic [63:0] ts_value = '0;

   logic [31:0] mem [0:63];
   logic [15:0] rlog [0:2047];
   logic [15:0] wlog [0:2047];
   int          rn = 0;
   int          wn = 0;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   txd_ts_closer uut (
      .clk(clk), .rst_n(rst_n), .poll_demand(poll_demand), .ring_base(BASE),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .xfer_req(xfer_req), .xfer_buf1_addr(xfer_buf1_addr),
      .xfer_buf1_len(xfer_buf1_len), .xfer_buf2_addr(xfer_buf2_addr),
      .xfer_buf2_len(xfer_buf2_len), .xfer_last(xfer_last),
      .xfer_done(xfer_done), .ts_value(ts_value), .suspended(suspended)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            mem[mem_addr[7:2]] <= mem_wdata;
            wlog[wn[10:0]] <= mem_addr;
            wn <= wn + 1;
         end else begin
            mem_rdata <= mem[mem_addr[7:2]];
            rlog[rn[10:0]] <= mem_addr;
            rn <= rn + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] close_exp(input logic [31:0] w0);
      logic [31:0] r = w0;
      r[31] = 1'b0;
      r[17] = w0[25] & w0[29];
      return r;
   endfunction

   // builds a descriptor at address a, stores it, and returns its successor address
   task automatic gen_desc(input logic [15:0] a, input int mode, input bit owned,
                           output logic [31:0] w0, output logic [31:0] w1,
                           output logic [31:0] w2, output logic [31:0] w3,
                           output logic [15:0] nxt);
      bit chained, eor;
      logic [3:0] slot;
      w0 = $urandom; w1 = $urandom; w2 = $urandom; w3 = $urandom;
      chained = ($urandom % 5) < 2;
      case (mode)
         1: begin w0[25] = 1; w0[29] = 1; chained = 0; end
         2: begin w0[25] = 1; w0[29] = 0; chained = 0; end
         3: begin w0[25] = 0; w0[29] = 1; chained = 0; end
         4: begin w0[25] = 1; w0[29] = 1; chained = 1; end
         default: ;
      endcase
      w0[31] = owned;
      w1[24] = chained;
      eor = (($urandom % 5) == 0);
      if (a == 16'h00F0) eor = 1;
      if (a == BASE) eor = 0;
      w0[21] = eor;
      if (chained) begin
         slot = 4'($urandom);
         if (slot == a[7:4]) slot = slot + 4'd1;
         w3[15:0] = {8'h00, slot, 2'b00, 2'($urandom)};
         nxt = {8'h00, slot, 4'h0};
      end else begin
         nxt = eor ? BASE : a + 16'd16;
      end
      mem[a[7:2]]     = w0;
      mem[a[7:2] + 1] = w1;
      mem[a[7:2] + 2] = w2;
      mem[a[7:2] + 3] = w3;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin @(posedge clk); cyc++; end
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] c0, c1, c2, c3, n0, n1, n2, n3;
      logic [15:0] cur, nxt, nn;
      logic [63:0] ts;
      bit          want;
      int          t, rs, ws;
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < 64; k++) mem[k] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(suspended == 1'b1, "R1 suspended after reset", 64'(suspended), 1);
      chk(xfer_req == 1'b0, "R1 no request after reset", 64'(xfer_req), 0);
      chk(rn == 0 && wn == 0, "R1 no memory access before poll", 64'(rn + wn), 0);

      cur = BASE;
      gen_desc(cur, 1, 1'b1, c0, c1, c2, c3, nxt);
      @(negedge clk) poll_demand = 1'b1;
      @(negedge clk) poll_demand = 1'b0;

      for (int i = 0; i < 40; i++) begin
         t = 0;
         while (!xfer_req && t < 300) begin @(negedge clk); t++; end
         chk(xfer_req == 1'b1, "R4 request raised", 64'(xfer_req), 1);
         if (i == 0) chk(rlog[0] == BASE, "R1 first fetch at ring base", rlog[0], BASE);
         chk(rn >= 4 && rlog[rn-4] == cur && rlog[rn-3] == cur + 16'd4 &&
             rlog[rn-2] == cur + 16'd8 && rlog[rn-1] == cur + 16'd12,
             "R2 fetch order", (rn >= 4) ? 64'(rlog[rn-4]) : 0, cur);
         chk(xfer_buf1_addr == c2 && xfer_buf2_addr == c3,
             "R4 buffer addresses", {xfer_buf1_addr, xfer_buf2_addr}, {c2, c3});
         chk(xfer_buf1_len == c1[12:0], "R4 buffer 1 length", xfer_buf1_len, c1[12:0]);
         chk(xfer_buf2_len == (c1[24] ? 13'd0 : c1[28:16]), "R4 buffer 2 length",
             xfer_buf2_len, c1[24] ? 13'd0 : c1[28:16]);
         chk(xfer_last == c0[29], "R4 last flag", 64'(xfer_last), 64'(c0[29]));

         gen_desc(nxt, (i < 3) ? i + 2 : 0, (i % 6) != 5, n0, n1, n2, n3, nn);

         repeat ($urandom % 4) @(negedge clk);
         chk(xfer_req == 1'b1, "R4 request held until done", 64'(xfer_req), 1);
         ws = wn; rs = rn;
         want = c0[25] & c0[29];
         ts = {$urandom, $urandom};
         xfer_done = 1'b1; ts_value = ts;
         @(negedge clk);
         xfer_done = 1'b0; ts_value = ~ts;
         t = 0;
         while (rn == rs && t < 50) begin @(negedge clk); t++; end

         if (want) begin
            chk(wn - ws == 3 && wlog[ws] == cur + 16'd8 && wlog[ws+1] == cur + 16'd12 &&
                wlog[ws+2] == cur, "R6 write order", 64'(wn - ws), 3);
            chk(mem[cur[7:2] + 2] == ts[31:0], "R5 low timestamp word",
                mem[cur[7:2] + 2], ts[31:0]);
            chk(mem[cur[7:2] + 3] == ts[63:32], "R5 high timestamp word",
                mem[cur[7:2] + 3], ts[63:32]);
         end else begin
            chk(wn - ws == 1 && wlog[ws] == cur, "R8 only word 0 written",
                64'(wn - ws), 1);
            chk(mem[cur[7:2] + 2] == c2 && mem[cur[7:2] + 3] == c3,
                "R8 pointer words kept", {mem[cur[7:2] + 2], mem[cur[7:2] + 3]}, {c2, c3});
         end
         chk(mem[cur[7:2]] == close_exp(c0), "R7 closing word",
             mem[cur[7:2]], close_exp(c0));
         if (c1[24])
            chk(rlog[rs] == nxt, "R9 chained next address", rlog[rs], nxt);
         else
            chk(rlog[rs] == nxt, "R10 ring next address", rlog[rs], nxt);

         if ((i % 6) == 5) begin
            t = 0;
            while (!suspended && t < 50) begin @(negedge clk); t++; end
            chk(suspended == 1'b1 && xfer_req == 1'b0, "R3 suspend on unowned",
                {suspended, xfer_req}, 2'b10);
            rs = rn; ws = wn;
            repeat (8) @(negedge clk);
            chk(rn == rs && wn == ws && xfer_req == 1'b0, "R3 quiet while suspended",
                64'(rn - rs + wn - ws), 0);
            n0[31] = 1'b1;
            mem[nxt[7:2]] = n0;
            poll_demand = 1'b1;
            @(negedge clk) poll_demand = 1'b0;
         end
         cur = nxt; nxt = nn;
         c0 = n0; c1 = n1; c2 = n2; c3 = n3;
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule